// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the clock that drives a memory-card bus from the master clock of the host controller. An 8-bit divide value N, taken from a control word, sets the card clock period. A build-time parameter picks one of two division laws. In the first law each half period lasts N+1 master cycles, so the period is 2*(N+1). In the second law the period is N+2 master cycles, with the high phase taking the smaller half. A bypass bit sends the master clock straight to the card pin and ignores N.

The card clock only runs while the enable bit is set. It also stops in two other cases. With power save set, it stops while neither the command path nor the data path reports activity. With flow control enabled, it stops while the data path requests a stall. A stopped clock always rests low. A high phase that is under way is finished first, so no pulse is ever cut short. The divide value is sampled only at the start of a period, so changing it never produces a partial period. Alongside the clock the block gives a one-cycle strobe, in the master domain, for each rising card-clock edge, and a decoded bus-width code.

Top module: `card_clk_div`

## Requirements
- R1: After reset, card_clk, clk_rise and bus_width are all 0.
- R2: While control bit 8 (enable) is 0, card_clk produces no rising edge and clk_rise stays 0.
- R3: With ALT_LAW=0, enable set and bypass clear, the card clock period is 2*(N+1) master cycles, high for N+1 of them, where N is control bits 7:0 (0 to 255).
- R4: With ALT_LAW=1, the period is N+2 master cycles, high for floor((N+2)/2) of them.
- R5: clk_rise is high for exactly one master cycle per rising card-clock edge, in the cycle in which card_clk first reads high.
- R6: A new N written while the clock runs takes effect only at the next rising edge; every period in between has the full old length or the full new length.
- R7: When control bit FC_BIT (13 by default) is set and stall_req is high, no new rising edge occurs and the clock rests low. With that bit clear, stall_req has no effect.
- R8: When control bit 9 (power save) is set and both busy_cmd and busy_dat are low, no new rising edge occurs. Activity on either input lets the clock run.
- R9: When control bit 10 (bypass) and enable are both set, card_clk follows the master clock (one card rise per master cycle) and clk_rise stays high.
- R10: bus_width is 2'b00 for a 1-bit bus, 2'b01 when control bit 11 is set, and 2'b10 when control bit 12 is set and WIDE8_EN=1; bit 12 takes priority over bit 11 and is ignored when WIDE8_EN=0. The code follows the control word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | CTRL_W (16) | Divide value and mode bits |
| stall_req | input | 1 | Stall request from the data path |
| busy_cmd | input | 1 | Command path active |
| busy_dat | input | 1 | Data path active |
| card_clk | output | 1 | Clock to the card bus |
| clk_rise | output | 1 | One-cycle strobe at each card-clock rise |
| bus_width | output | 2 | Bus width code |

## Verification
Periods and high times are measured at the smallest N (0 and 1), at a mid value, and at the largest N (255), under both laws. The mid value separates the two laws, and the extremes expose off-by-one errors and counter overflow. Rise counts over fixed windows tell running from stopped, with stall, power save and enable each toggled separately. Bypass is told apart from divide-by-two by its rate of one rise per master cycle. A divide change made partway through a high phase checks that every period has either the full old length or the full new length.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [1:0] {
        BW_ONE   = 2'b00,
        BW_FOUR  = 2'b01,
        BW_EIGHT = 2'b10
    } ccd_bw_e;

    function automatic ccd_bw_e bw_decode(input logic w4, input logic w8, input logic allow8);
        if (w8 && allow8) return BW_EIGHT;
        if (w4)           return BW_FOUR;
        return BW_ONE;
    endfunction

endpackage

// File: rtl/ccd_period.sv
// Phase lengths for the selected divide law.
module ccd_period #(
    parameter int DIV_W   = 8,
    parameter bit ALT_LAW = 0,
    localparam int LEN_W  = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div,
    output logic [LEN_W-1:0] hi_len,
    output logic [LEN_W-1:0] lo_len
);
    generate
        if (ALT_LAW) begin : g_sum
            logic [LEN_W-1:0] total;
            assign total  = {1'b0, div} + LEN_W'(2);
            assign hi_len = total >> 1;
            assign lo_len = total - (total >> 1);
        end else begin : g_twice
            assign hi_len = {1'b0, div} + LEN_W'(1);
            assign lo_len = {1'b0, div} + LEN_W'(1);
        end
    endgenerate
endmodule

// File: rtl/ccd_gate.sv
// Decides whether the card clock may advance into a new high phase.
module ccd_gate (
    input  logic enable,
    input  logic pwr_save,
    input  logic fc_en,
    input  logic stall_req,
    input  logic busy_cmd,
    input  logic busy_dat,
    output logic run
);
    logic idle_block;
    logic stall_block;

    assign idle_block  = pwr_save && !busy_cmd && !busy_dat;
    assign stall_block = fc_en && stall_req;
    assign run         = enable && !idle_block && !stall_block;
endmodule

// File: rtl/ccd_bypass.sv
// Passes the master clock through; the gate flop changes on the low phase only.
module ccd_bypass (
    input  logic clk_mst,
    input  logic rst_n,
    input  logic pass_en,
    output logic clk_out
);
    logic open_q;

    always_ff @(negedge clk_mst or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= pass_en;
    end

    assign clk_out = clk_mst & open_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int CTRL_W   = 16,
    parameter int FC_BIT   = 13,
    parameter bit ALT_LAW  = 0,
    parameter bit WIDE8_EN = 1
) (
    input  logic              clk_mst,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              stall_req,
    input  logic              busy_cmd,
    input  logic              busy_dat,
    output logic              card_clk,
    output logic              clk_rise,
    output logic [1:0]        bus_width
);
    localparam int LEN_W   = DIV_W + 1;
    localparam int EN_BIT  = DIV_W;
    localparam int PS_BIT  = DIV_W + 1;
    localparam int BYP_BIT = DIV_W + 2;
    localparam int W4_BIT  = DIV_W + 3;
    localparam int W8_BIT  = DIV_W + 4;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             phase;
        logic             rise;
        logic [DIV_W-1:0] div;
        ccd_bw_e          width;
    } st_t;

    st_t s_d, s_q;

    logic [LEN_W-1:0] hi_len, lo_len, lim;
    logic             run, last, byp, byp_clk;
    logic [DIV_W-1:0] div_new;

    assign byp     = ctrl_word[BYP_BIT];
    assign div_new = ctrl_word[DIV_W-1:0];

    ccd_period #(.DIV_W(DIV_W), .ALT_LAW(ALT_LAW)) u_per (
        .div    (s_q.div),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    ccd_gate u_gate (
        .enable    (ctrl_word[EN_BIT]),
        .pwr_save  (ctrl_word[PS_BIT]),
        .fc_en     (ctrl_word[FC_BIT]),
        .stall_req (stall_req),
        .busy_cmd  (busy_cmd),
        .busy_dat  (busy_dat),
        .run       (run)
    );

    ccd_bypass u_byp (
        .clk_mst (clk_mst),
        .rst_n   (rst_n),
        .pass_en (byp && run),
        .clk_out (byp_clk)
    );

    assign lim  = s_q.phase ? hi_len : lo_len;
    assign last = (s_q.cnt == lim - LEN_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.rise  = 1'b0;
        s_d.width = bw_decode(ctrl_word[W4_BIT], ctrl_word[W8_BIT], WIDE8_EN);
        if (byp) begin
            s_d.phase = 1'b0;
            s_d.cnt   = '0;
            s_d.div   = div_new;
            s_d.rise  = run;
        end else if (s_q.phase) begin
            // a high phase always runs to its end
            if (last) begin
                s_d.phase = 1'b0;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + LEN_W'(1);
            end
        end else if (!run) begin
            // rest low; the divide value may be reloaded safely here
            s_d.cnt = '0;
            s_d.div = div_new;
        end else if (last) begin
            s_d.phase = 1'b1;
            s_d.cnt   = '0;
            s_d.rise  = 1'b1;
            s_d.div   = div_new;
        end else begin
            s_d.cnt = s_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, phase: 1'b0, rise: 1'b0, div: '0, width: BW_ONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign card_clk  = byp_clk | s_q.phase;
    assign clk_rise  = s_q.rise;
    assign bus_width = s_q.width;
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk #(
    parameter int DIV_W    = 8,
    parameter int CTRL_W   = 16,
    parameter int FC_BIT   = 13,
    parameter bit WIDE8_EN = 1
) (
    input logic              clk_mst,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              stall_req,
    input logic              busy_cmd,
    input logic              busy_dat,
    input logic              card_clk,
    input logic              clk_rise,
    input logic [1:0]        bus_width
);
    localparam int EN_BIT  = DIV_W;
    localparam int PS_BIT  = DIV_W + 1;
    localparam int BYP_BIT = DIV_W + 2;
    localparam int W8_BIT  = DIV_W + 4;

    a_r2_off_no_rise: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !ctrl_word[EN_BIT] |=> !clk_rise);

    a_r7_stall_no_rise: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (ctrl_word[FC_BIT] && stall_req) |=> !clk_rise);

    a_r8_idle_no_rise: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (ctrl_word[PS_BIT] && !busy_cmd && !busy_dat) |=> !clk_rise);

    a_r5_strobe_on_high: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (clk_rise && !$past(ctrl_word[BYP_BIT])) |-> card_clk);

    a_r10_eight_bit: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (WIDE8_EN && ctrl_word[W8_BIT]) |=> (bus_width == 2'b10));
endmodule

bind card_clk_div ccd_chk #(
    .DIV_W(DIV_W), .CTRL_W(CTRL_W), .FC_BIT(FC_BIT), .WIDE8_EN(WIDE8_EN)
) u_chk (.*);

// File: tb/sim_card_clk_div.sv
module sim_card_clk_div;
    localparam int EN = 1 << 8, PS = 1 << 9, BYP = 1 << 10, W4 = 1 << 11, W8 = 1 << 12, FC = 1 << 13;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] ctrl0 = '0, ctrl1 = '0;
    logic        stall = 1'b0, bcmd = 1'b0, bdat = 1'b0;
    logic        cc0, cc1, rs0, rs1;
    logic [1:0]  bw0, bw1;

    card_clk_div u0 (.clk_mst(clk), .rst_n(rst_n), .ctrl_word(ctrl0), .stall_req(stall),
        .busy_cmd(bcmd), .busy_dat(bdat), .card_clk(cc0), .clk_rise(rs0), .bus_width(bw0));
    card_clk_div #(.ALT_LAW(1), .WIDE8_EN(0)) u1 (.clk_mst(clk), .rst_n(rst_n), .ctrl_word(ctrl1),
        .stall_req(stall), .busy_cmd(bcmd), .busy_dat(bdat), .card_clk(cc1), .clk_rise(rs1), .bus_width(bw1));

    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct { int per; int hi; string req; } item_t;
    item_t sbq[$];
    int    logp[$];
    bit    sel = 0, skip = 0, logging = 0, prev = 0;
    int    per = 0, hi = 0, rc0 = 0, rc1 = 0;

    always @(posedge cc0) rc0++;
    always @(posedge cc1) rc1++;

    // monitor: measures each period and high time, pops expected items
    always @(negedge clk) begin
        logic c, r;
        item_t it;
        c = sel ? cc1 : cc0;
        r = sel ? rs1 : rs0;
        per++;
        if (c && !prev) begin
            if (skip) skip = 0;
            else begin
                if (logging) logp.push_back(per);
                if (sbq.size() > 0) begin
                    it = sbq.pop_front();
                    chk(per == it.per, {it.req, " period"}, per, it.per);
                    chk(hi == it.hi, {it.req, " high"}, hi, it.hi);
                    chk(r, "R5 strobe at rise", int'(r), 1);
                end
            end
            per = 0;
            hi = 0;
        end
        if (c) hi++;
        prev = c;
    end

    task automatic wait_rises(input bit s, input int k);
        int b;
        b = s ? rc1 : rc0;
        wait ((s ? rc1 : rc0) >= b + k);
    endtask

    task automatic count_win(input bit s, input int cyc, output int n);
        int b;
        @(negedge clk);
        b = s ? rc1 : rc0;
        repeat (cyc) @(negedge clk);
        n = (s ? rc1 : rc0) - b;
    endtask

    // driver: pushes expected periods and waits until the monitor has used them
    task automatic measure(input bit s, input int n, input string req, input int k);
        item_t it;
        if (s) ctrl1 = 16'(EN | n); else ctrl0 = 16'(EN | n);
        wait_rises(s, 3);
        sel = s;
        skip = 1;
        it.req = req;
        if (s) begin it.per = n + 2; it.hi = (n + 2) / 2; end
        else   begin it.per = 2 * (n + 1); it.hi = n + 1; end
        for (int i = 0; i < k; i++) sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cc0 == 0 && cc1 == 0, "R1 card_clk", int'(cc0 | cc1), 0);
        chk(rs0 == 0, "R1 clk_rise", int'(rs0), 0);
        chk(bw0 == 0, "R1 bus_width", int'(bw0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 enable off
        ctrl0 = 16'(1);
        count_win(0, 60, n);
        chk(n == 0, "R2 rises while disabled", n, 0);
        chk(rs0 == 0, "R2 strobe while disabled", int'(rs0), 0);

        // R3 law 2*(N+1)
        measure(0, 0, "R3 N=0", 3);
        measure(0, 1, "R3 N=1", 3);
        measure(0, 5, "R3 N=5", 3);
        measure(0, 255, "R3 N=255", 2);
        // R4 law N+2
        measure(1, 0, "R4 N=0", 3);
        measure(1, 1, "R4 N=1", 3);
        measure(1, 6, "R4 N=6", 3);
        measure(1, 255, "R4 N=255", 2);

        // R5 strobe count equals rise count over a window
        ctrl0 = 16'(EN | 1);
        wait_rises(0, 3);
        begin
            int b, st;
            st = 0;
            @(negedge clk);
            b = rc0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (rs0) st++;
            end
            chk(st == rc0 - b, "R5 strobes per rises", st, rc0 - b);
            chk(st == 15, "R5 strobe count", st, 15);
        end

        // R6 divider change during a high phase
        ctrl0 = 16'(EN | 3);
        wait_rises(0, 3);
        sel = 0; skip = 1; logp.delete(); logging = 1;
        wait_rises(0, 2);
        ctrl0 = 16'(EN | 7);
        wait_rises(0, 4);
        logging = 0;
        foreach (logp[i]) chk(logp[i] == 8 || logp[i] == 16, "R6 whole period", logp[i], 16);
        chk(logp.size() > 0 && logp[logp.size()-1] == 16, "R6 new period", logp[logp.size()-1], 16);

        // R7 flow-control stall
        ctrl0 = 16'(EN | FC | 1);
        stall = 1;
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 0, "R7 stalled", n, 0);
        chk(cc0 == 0, "R7 rests low", int'(cc0), 0);
        stall = 0;
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 15, "R7 released", n, 15);
        ctrl0 = 16'(EN | 1);
        stall = 1;
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 15, "R7 stall ignored without enable bit", n, 15);
        stall = 0;

        // R8 power save
        ctrl0 = 16'(EN | PS | 1);
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 0, "R8 idle gated", n, 0);
        bdat = 1;
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 15, "R8 data busy runs", n, 15);
        bdat = 0; bcmd = 1;
        repeat (10) @(negedge clk);
        count_win(0, 60, n);
        chk(n == 15, "R8 cmd busy runs", n, 15);
        bcmd = 0;

        // R9 bypass
        ctrl0 = 16'(EN | BYP | 9);
        repeat (5) @(negedge clk);
        count_win(0, 20, n);
        chk(n == 20, "R9 bypass rate", n, 20);
        chk(rs0 == 1, "R9 strobe steady", int'(rs0), 1);
        ctrl0 = 16'(BYP | 9);
        repeat (5) @(negedge clk);
        count_win(0, 20, n);
        chk(n == 0, "R9 bypass needs enable", n, 0);

        // R10 bus width
        ctrl0 = 16'(W4); repeat (2) @(negedge clk);
        chk(bw0 == 2'b01, "R10 four-bit", int'(bw0), 1);
        ctrl0 = 16'(W8); repeat (2) @(negedge clk);
        chk(bw0 == 2'b10, "R10 eight-bit", int'(bw0), 2);
        ctrl0 = 16'(W4 | W8); repeat (2) @(negedge clk);
        chk(bw0 == 2'b10, "R10 priority", int'(bw0), 2);
        ctrl0 = 16'(0); repeat (2) @(negedge clk);
        chk(bw0 == 2'b00, "R10 one-bit", int'(bw0), 0);
        ctrl1 = 16'(W8); repeat (2) @(negedge clk);
        chk(bw1 == 2'b00, "R10 eight-bit ignored", int'(bw1), 0);
        ctrl1 = 16'(W4 | W8); repeat (2) @(negedge clk);
        chk(bw1 == 2'b01, "R10 four-bit when eight absent", int'(bw1), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule